// File: doc/BRIEF.md
# TDM Frame-Synchronizing Demultiplexer

This block sits on the receive side of a time-division multiplexed serial link. The incoming stream is built from repeating frames. Each frame is one frame bit followed by a fixed number of timeslot bits. The frame bit alternates between 0 and 1 from one frame to the next. The block first finds where the frame bit falls in the stream. It then holds that alignment with a position counter and watches for frame-bit errors.

While aligned, the block looks up every timeslot in a programmable slot table. The table must hold the same assignment as the transmit end. Each slot's bit goes to one of 16 per-port FIFOs, to the management receive link, or is thrown away. Each port FIFO drives its own serial line and is drained one bit per tick from the port. An `in_sync` status and a per-frame pulse let the system follow the alignment state.

Top module: `tdm_frame_demux`

## Requirements
- R1: The block declares `in_sync` once the same candidate position has carried a frame bit that alternates over 4 consecutive frames. A stream whose candidate bit does not alternate never brings `in_sync` high. On a mismatch during search, the candidate moves one bit later.
- R2: The position counter advances only on cycles with `rx_valid` high. `frame_pulse` is high for one cycle after each frame bit sampled while already in sync.
- R3: While in sync, 3 consecutive frame bits with the wrong polarity drop `in_sync`, and the drop takes effect after the third of them. One or two wrong frame bits followed by a correct one leave lock intact.
- R4: A table entry of 0 to 15 sends that slot's bit to the FIFO of the port with that number. `port_txd[i]` shows the oldest stored bit of port i, or 1 when that FIFO is empty. A `port_tick[i]` pulse removes the oldest bit. Bits leave in the order they arrived.
- R5: Entry 16 sends the slot's bit to the management link. `mgmt_valid` is high for the cycle after that bit, and `mgmt_bit` carries its value.
- R6: Entry 31, and any other value from 17 to 30, discards the slot's bit. Every table entry resets to 31. A write on `tbl_wr_en` sets slot `tbl_wr_slot` to `tbl_wr_entry`, starting with the next cycle.
- R7: While not in sync, no bit is written to any port FIFO and no management bit is delivered.
- R8: A bit for a port whose FIFO already holds DEPTH (4) bits is dropped, and `port_ovf[i]` goes high and stays high until reset. A FIFO counts as full before any tick in the same cycle takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received bit valid this cycle |
| rx_bit | input | 1 | Received serial bit |
| tbl_wr_en | input | 1 | Slot table write strobe |
| tbl_wr_slot | input | 5 | Slot index to write (0 to 22) |
| tbl_wr_entry | input | 5 | Routing code for that slot |
| port_tick | input | 16 | Per-port request to shift out one bit |
| port_txd | output | 16 | Per-port serial output |
| port_ovf | output | 16 | Per-port sticky overflow flag |
| mgmt_valid | output | 1 | Management bit valid |
| mgmt_bit | output | 1 | Management bit |
| in_sync | output | 1 | Frame alignment held |
| frame_pulse | output | 1 | One-cycle pulse per frame while in sync |

## Verification
The bench first sends a stream whose candidate bit never alternates. This tells a correct detector apart from one that locks on any steady position. Next come frames with all-zero payload behind a junk prefix, so the search must slip bit by bit until it reaches the true frame bit. Random payload with idle gaps, random ticks and one undrained port then separates correct routing, draining order and overflow behaviour. Last, runs of two and then three inverted frame bits distinguish tolerated errors from loss of lock, and the stretch that follows confirms the search stays silent on every output.

// File: rtl/tdm_demux_pkg.sv
package tdm_demux_pkg;
  localparam int ENT_W    = 5;
  localparam int ENC_MGMT = 16;
  localparam int ENC_DROP = 31;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } sync_state_t;
endpackage

// File: rtl/tdm_frame_sync.sv
module tdm_frame_sync
  import tdm_demux_pkg::*;
#(
  parameter int NSLOTS      = 23,
  parameter int LOCK_FRAMES = 4,
  parameter int LOSS_ERRS   = 3,
  parameter int POS_W       = $clog2(NSLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_bit,
  output logic             in_sync,
  output logic [POS_W-1:0] pos,
  output logic             frame_pulse
);
  localparam int FLEN = NSLOTS + 1;
  localparam int HW   = $clog2(LOCK_FRAMES + 1);
  localparam int EW   = $clog2(LOSS_ERRS + 1);

  sync_state_t      st_q, st_n;
  logic [POS_W-1:0] pos_q, pos_n;
  logic [HW-1:0]    hits_q, hits_n;
  logic [EW-1:0]    errs_q, errs_n;
  logic             ref_q, ref_n;
  logic             pulse_q, pulse_n;
  logic             at_fbit;

  assign at_fbit = (pos_q == '0);

  always_comb begin
    st_n    = st_q;
    pos_n   = pos_q;
    hits_n  = hits_q;
    errs_n  = errs_q;
    ref_n   = ref_q;
    pulse_n = 1'b0;
    if (rx_valid) begin
      pos_n = (pos_q == POS_W'(FLEN - 1)) ? '0 : pos_q + 1'b1;
      if (at_fbit) begin
        if (st_q == ST_SEARCH) begin
          if (hits_q == '0) begin
            ref_n  = rx_bit;
            hits_n = HW'(1);
          end else if (rx_bit != ref_q) begin
            ref_n = rx_bit;
            if (hits_q == HW'(LOCK_FRAMES - 1)) begin
              st_n   = ST_LOCKED;
              hits_n = '0;
              errs_n = '0;
            end else begin
              hits_n = hits_q + 1'b1;
            end
          end else begin
            pos_n  = pos_q;          // slip: candidate moves one bit later
            hits_n = '0;
          end
        end else begin
          pulse_n = 1'b1;
          ref_n   = ~ref_q;
          if (rx_bit == ~ref_q) begin
            errs_n = '0;
          end else if (errs_q == EW'(LOSS_ERRS - 1)) begin
            st_n   = ST_SEARCH;
            hits_n = '0;
          end else begin
            errs_n = errs_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_SEARCH;
      pos_q   <= '0;
      hits_q  <= '0;
      errs_q  <= '0;
      ref_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      pos_q   <= pos_n;
      hits_q  <= hits_n;
      errs_q  <= errs_n;
      ref_q   <= ref_n;
      pulse_q <= pulse_n;
    end
  end

  assign in_sync     = (st_q == ST_LOCKED);
  assign pos         = pos_q;
  assign frame_pulse = pulse_q;

  // R1: lock is only ever declared on a sampled frame-bit position
  p_lock_at_fbit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> ($past(rx_valid) && $past(pos_q) == '0));
  // R2: position frozen when no bit arrives
  p_pos_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> $stable(pos_q));
  // R2: frame pulse only follows a frame bit taken while in sync
  p_pulse_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |-> ($past(in_sync) && $past(pos_q) == '0));
  // R3: loss of lock only at a frame-bit position
  p_loss_at_fbit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_sync) |-> ($past(rx_valid) && $past(pos_q) == '0));
endmodule

// File: rtl/tdm_slot_table.sv
module tdm_slot_table
  import tdm_demux_pkg::*;
#(
  parameter int NSLOTS = 23,
  parameter int SLOT_W = $clog2(NSLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [ENT_W-1:0]  wr_entry,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [ENT_W-1:0]  rd_entry
);
  logic [ENT_W-1:0] ent_q [NSLOTS];

  generate
    for (genvar s = 0; s < NSLOTS; s++) begin : g_ent
      logic hit;
      assign hit = wr_en && (wr_slot == SLOT_W'(s));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   ent_q[s] <= ENT_W'(ENC_DROP);
        else if (hit) ent_q[s] <= wr_entry;
      end
    end
  endgenerate

  assign rd_entry = (rd_slot < SLOT_W'(NSLOTS)) ? ent_q[rd_slot] : ENT_W'(ENC_DROP);
endmodule

// File: rtl/tdm_port_fifo.sv
module tdm_port_fifo #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic rd_tick,
  output logic txd,
  output logic ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] mem_q;
  logic [AW-1:0]    wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0]    cnt_q, cnt_n;
  logic             ovf_q, ovf_n;
  logic             full, empty, push, pop;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign push  = wr_en && !full;
  assign pop   = rd_tick && !empty;

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    ovf_n = ovf_q | (wr_en && full);
    if (push) wp_n = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop)  rp_n = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (push && !pop)      cnt_n = cnt_q + 1'b1;
    else if (pop && !push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= wr_bit;
  end

  assign txd = empty ? 1'b1 : mem_q[rp_q];
  assign ovf = ovf_q;

  // R8: a write into a full FIFO raises the sticky flag
  p_full_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> ovf);
  // R8: flag never clears outside reset
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R4: occupancy stays within the storage
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/tdm_frame_demux.sv
module tdm_frame_demux
  import tdm_demux_pkg::*;
#(
  parameter int NPORTS      = 16,
  parameter int NSLOTS      = 23,
  parameter int FIFO_DEPTH  = 4,
  parameter int LOCK_FRAMES = 4,
  parameter int LOSS_ERRS   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rx_valid,
  input  logic                        rx_bit,
  input  logic                        tbl_wr_en,
  input  logic [$clog2(NSLOTS)-1:0]   tbl_wr_slot,
  input  logic [4:0]                  tbl_wr_entry,
  input  logic [NPORTS-1:0]           port_tick,
  output logic [NPORTS-1:0]           port_txd,
  output logic [NPORTS-1:0]           port_ovf,
  output logic                        mgmt_valid,
  output logic                        mgmt_bit,
  output logic                        in_sync,
  output logic                        frame_pulse
);
  localparam int SLOT_W = $clog2(NSLOTS);
  localparam int POS_W  = $clog2(NSLOTS + 1);

  logic [POS_W-1:0]  pos;
  logic [SLOT_W-1:0] slot_idx;
  logic [ENT_W-1:0]  entry;
  logic              data_slot;
  logic              mgmt_hit;
  logic [NPORTS-1:0] port_wr;
  logic              mv_q, mb_q;

  tdm_frame_sync #(
    .NSLOTS(NSLOTS), .LOCK_FRAMES(LOCK_FRAMES), .LOSS_ERRS(LOSS_ERRS), .POS_W(POS_W)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .in_sync(in_sync), .pos(pos), .frame_pulse(frame_pulse)
  );

  assign slot_idx = SLOT_W'(pos - 1'b1);

  tdm_slot_table #(.NSLOTS(NSLOTS), .SLOT_W(SLOT_W)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_slot(tbl_wr_slot),
    .wr_entry(tbl_wr_entry), .rd_slot(slot_idx), .rd_entry(entry)
  );

  assign data_slot = rx_valid && in_sync && (pos != '0);
  assign mgmt_hit  = data_slot && (entry == ENT_W'(ENC_MGMT));

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
      assign port_wr[p] = data_slot && (entry == ENT_W'(p));
      tdm_port_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(port_wr[p]), .wr_bit(rx_bit),
        .rd_tick(port_tick[p]), .txd(port_txd[p]), .ovf(port_ovf[p])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv_q <= 1'b0;
      mb_q <= 1'b0;
    end else begin
      mv_q <= mgmt_hit;
      if (mgmt_hit) mb_q <= rx_bit;
    end
  end

  assign mgmt_valid = mv_q;
  assign mgmt_bit   = mb_q;

  // R4: at most one destination per received bit
  p_one_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mgmt_hit, port_wr}));
  // R7: search state writes nowhere
  p_search_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sync |-> (port_wr == '0));
  // R5: management bit only follows a bit taken while in sync
  p_mgmt_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_valid |-> ($past(in_sync) && $past(rx_valid)));
endmodule

// File: tb/tb_tdm_frame_demux.sv
module tb_tdm_frame_demux;
  localparam int NP = 16;
  localparam int NS = 23;
  localparam int FL = NS + 1;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_valid, rx_bit, tbl_wr_en;
  logic [4:0] tbl_wr_slot, tbl_wr_entry;
  logic [NP-1:0] port_tick, port_txd, port_ovf;
  logic mgmt_valid, mgmt_bit, in_sync, frame_pulse;

  always #10 clk = ~clk;   // 50 MHz

  tdm_frame_demux dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_slot(tbl_wr_slot), .tbl_wr_entry(tbl_wr_entry),
    .port_tick(port_tick), .port_txd(port_txd), .port_ovf(port_ovf),
    .mgmt_valid(mgmt_valid), .mgmt_bit(mgmt_bit), .in_sync(in_sync),
    .frame_pulse(frame_pulse)
  );

  int total = 0, bad = 0, cycles = 0, mgmt_seen = 0, pulse_seen = 0;
  bit done = 0;

  // reference state
  int m_lock, m_pos, m_hits, m_errs, m_ref, m_pulse, m_mv, m_mb;
  int m_tab [NS];
  int q [NP][$];
  int m_ovf [NP];

  // stimulus controls
  bit gaps = 0, tick_on = 1, fph = 0;
  bit tw_en = 0; int tw_slot = 0, tw_ent = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(in_sync == m_lock[0], "R1 in_sync", in_sync, m_lock);
    chk(frame_pulse == m_pulse[0], "R2 frame_pulse", frame_pulse, m_pulse);
    chk(mgmt_valid == m_mv[0], "R5 mgmt_valid", mgmt_valid, m_mv);
    if (m_mv != 0) chk(mgmt_bit == m_mb[0], "R5 mgmt_bit", mgmt_bit, m_mb);
    for (int p = 0; p < NP; p++) begin
      int e;
      e = (q[p].size() > 0) ? q[p][0] : 1;
      chk(port_txd[p] == e[0], "R4 port_txd", port_txd[p], e);
      chk(port_ovf[p] == m_ovf[p][0], "R8 port_ovf", port_ovf[p], m_ovf[p]);
    end
    if (mgmt_valid) mgmt_seen++;
    if (frame_pulse) pulse_seen++;
  endtask

  task automatic model(input bit v, input bit b, input logic [NP-1:0] tk);
    bit fb, adv;
    int dest;
    bit pre_full [NP];
    dest = -1;
    fb = (m_pos == 0);
    for (int p = 0; p < NP; p++) pre_full[p] = (q[p].size() >= DEPTH);
    m_pulse = (v && fb && m_lock != 0) ? 1 : 0;
    m_mv = 0;
    if (v && m_lock != 0 && !fb) dest = m_tab[m_pos - 1];
    for (int p = 0; p < NP; p++)
      if (tk[p] && q[p].size() > 0) void'(q[p].pop_front());
    if (dest >= 0 && dest < NP) begin
      if (pre_full[dest]) m_ovf[dest] = 1;
      else q[dest].push_back(b);
    end else if (dest == 16) begin
      m_mv = 1; m_mb = b;
    end
    if (v) begin
      adv = 1;
      if (fb) begin
        if (m_lock == 0) begin
          if (m_hits == 0) begin m_ref = b; m_hits = 1; end
          else if (b != m_ref[0]) begin
            m_ref = b;
            if (m_hits == 3) begin m_lock = 1; m_hits = 0; m_errs = 0; end
            else m_hits++;
          end else begin m_hits = 0; adv = 0; end
        end else begin
          m_ref = (m_ref != 0) ? 0 : 1;
          if (b == m_ref[0]) m_errs = 0;
          else if (m_errs == 2) begin m_lock = 0; m_hits = 0; end
          else m_errs++;
        end
      end
      if (adv) m_pos = (m_pos + 1) % FL;
    end
    if (tw_en && tw_slot < NS) m_tab[tw_slot] = tw_ent;
  endtask

  task automatic step(input bit v, input bit b);
    logic [NP-1:0] tk;
    compare_all();
    tk = tick_on ? NP'($urandom) : '0;
    tk[5] = 1'b0;                       // port 5 is never drained
    rx_valid = v; rx_bit = b; port_tick = tk;
    tbl_wr_en = tw_en; tbl_wr_slot = 5'(tw_slot); tbl_wr_entry = 5'(tw_ent);
    model(v, b, tk);
    tw_en = 0;
    @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    if (gaps && ($urandom % 4 == 0)) step(0, 0);
    step(1, b);
  endtask

  task automatic send_frame(input bit corrupt, input bit zero_data);
    send_bit(corrupt ? ~fph : fph);
    fph = ~fph;
    for (int s = 0; s < NS; s++) send_bit(zero_data ? 1'b0 : 1'($urandom));
  endtask

  task automatic tbl_write(input int slot, input int ent);
    tw_en = 1; tw_slot = slot; tw_ent = ent;
    step(0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired act=%0d exp=0", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 0; rx_valid = 0; rx_bit = 0; tbl_wr_en = 0;
    tbl_wr_slot = 0; tbl_wr_entry = 0; port_tick = 0;
    m_lock = 0; m_pos = 0; m_hits = 0; m_errs = 0; m_ref = 0;
    m_pulse = 0; m_mv = 0; m_mb = 0;
    for (int s = 0; s < NS; s++) m_tab[s] = 31;   // R6 reset value
    for (int p = 0; p < NP; p++) m_ovf[p] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    chk(in_sync == 0, "R1 reset in_sync", in_sync, 0);
    chk(port_txd == '1, "R4 reset txd idle", int'(port_txd), 16'hFFFF);
    chk(port_ovf == '0, "R8 reset ovf", int'(port_ovf), 0);
    chk(mgmt_valid == 0, "R5 reset mgmt", mgmt_valid, 0);
    chk(frame_pulse == 0, "R2 reset pulse", frame_pulse, 0);

    // non-alternating stream must never lock
    repeat (200) step(1, 1);
    chk(in_sync == 0, "R1 steady stream no lock", in_sync, 0);

    // junk prefix, then zero-payload frames: search must slip to true frame bit
    repeat (5) step(1, 1);
    repeat (40) send_frame(0, 1);
    chk(in_sync == 1, "R1 lock after search", in_sync, 1);
    mgmt_seen = 0;
    repeat (4) send_frame(0, 0);
    chk(port_txd == '1, "R6 default table discards", int'(port_txd), 16'hFFFF);
    chk(mgmt_seen == 0, "R6 default table no mgmt", mgmt_seen, 0);

    // program table: slot s -> port s, slot 16 -> mgmt, slot 20 -> port 3, others drop
    for (int s = 0; s < 16; s++) tbl_write(s, s);
    tbl_write(16, 16);
    tbl_write(20, 3);
    tbl_write(21, 25);                   // R6: unused code discards

    // routing with gaps and random draining
    gaps = 1; mgmt_seen = 0; pulse_seen = 0;
    repeat (12) send_frame(0, 0);
    chk(port_ovf[5] == 1, "R8 undrained port overflows", port_ovf[5], 1);
    chk(port_ovf[0] == 0, "R8 drained port clean", port_ovf[0], 0);
    chk(mgmt_seen > 0, "R5 management delivered", mgmt_seen, 12);
    chk(pulse_seen == 12, "R2 one pulse per frame", pulse_seen, 12);

    // two bad frame bits tolerated
    send_frame(1, 0); send_frame(1, 0);
    chk(in_sync == 1, "R3 two errors keep lock", in_sync, 1);
    send_frame(0, 0);
    // three bad frame bits lose lock
    send_frame(1, 0); send_frame(1, 0); send_frame(1, 0);
    chk(in_sync == 0, "R3 three errors drop lock", in_sync, 0);
    mgmt_seen = 0;
    send_frame(0, 0); send_frame(0, 0);
    chk(mgmt_seen == 0, "R7 no delivery during search", mgmt_seen, 0);
    repeat (6) send_frame(0, 0);
    chk(in_sync == 1, "R1 relock", in_sync, 1);

    // drain everything and finish
    gaps = 0;
    repeat (40) step(0, 0);
    finish_run();
  end
endmodule